// File: doc/BRIEF.md
# Approximate Adder with On-Demand Carry Repair

This block adds two N-bit operands with a segmented adder whose carry chain is cut into short windows, so the usual add finishes within one short window delay. The result is split into K-bit slices. Slice 0 is an ordinary K-bit add. Each higher slice is taken from a 2K-bit sub-adder. That sub-adder spans the slice and the slice below it, and its carry-in is tied to zero. The approximation is wrong only when a carry generated two or more slices down runs across a slice whose bits all propagate.

Every cycle, a cheap per-slice detector compares the low half of each window with the carry that the window below produced internally. If no slice is flagged, the registered approximate sum is already exact and is presented one cycle after acceptance. If any slice is flagged, the block drops its ready for one cycle. During that cycle it repairs the stored sum by incrementing the flagged slices, working from the least significant slice upward. An incremented slice that overflows feeds its carry to the next slice. The exact sum is then presented one cycle later than usual, marked by a repair flag. Upstream logic sees a plain valid/ready handshake whose latency varies with the data. The output has no back-pressure.

Top module: `approx_fix_adder`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, out_valid is 0 and in_ready is 1.
- R2: An operand pair accepted at a clock edge (in_valid and in_ready both 1) that needs no repair gives out_valid=1 in the following cycle. In that cycle out_sum equals the exact in_a+in_b, with the carry out in bit N, and out_corr is 0.
- R3: Repair is needed exactly when the windowed sum differs from the exact sum. In the windowed sum, slice j≥1 (bits jK+K-1..jK) is the upper half of the sum of bits jK+K-1..jK-K with carry-in 0. The top window's carry out supplies bit N. An accepted pair that needs repair makes in_ready 0 in the cycle after acceptance.
- R4: in_ready is never 0 for two cycles in a row. After a repair stall it returns to 1.
- R5: A repaired pair gives out_valid=1 two cycles after acceptance, with out_sum equal to the exact in_a+in_b and out_corr=1.
- R6: The repair is exact when the lost carry must cross several all-propagate slices, including a carry that reaches bit N.
- R7: out_valid is 1 only in a cycle where an accepted result falls due. There is exactly one output per accepted pair, and outputs come in acceptance order.
- R8: An operand pair offered while in_ready is 0 is not taken. It is accepted at the next edge where in_ready is 1, and its result is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_a | input | N | First operand |
| in_b | input | N | Second operand |
| out_valid | output | 1 | out_sum holds a result this cycle |
| out_sum | output | N+1 | Exact sum, carry out in bit N |
| out_corr | output | 1 | Result went through the repair cycle |

## Verification
The bench builds the block with N=16 and K=4, which gives four slices. With that split, only the top two slices can ever be flagged. Random operands are biased toward all-propagate nibbles, so repairs are frequent, and stalls often fall while the next pair is already offered. Directed pairs push a carry from slice 0 across every higher slice and into bit 16, which exercises the overflow ripple through the incrementors.

// File: rtl/approx_fix_adder.sv
module approx_fix_adder #(
  parameter int N = 16,
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_a,
  input  logic [N-1:0] in_b,
  output logic         out_valid,
  output logic [N:0]   out_sum,
  output logic         out_corr
);
  localparam int M = N / K;
  localparam int W = 2 * K;

  logic [N:0]   apx;
  logic [M-1:0] err;

  for (genvar j = 0; j < M; j++) begin : g_slc
    if (j == 0) begin : g_base
      assign apx[K-1:0] = in_a[K-1:0] + in_b[K-1:0];
      assign err[0] = 1'b0;
    end else begin : g_win
      logic [W:0] win;
      assign win = {1'b0, in_a[(j-1)*K +: W]} + {1'b0, in_b[(j-1)*K +: W]};
      assign apx[j*K +: K] = win[W-1:K];
      if (j == M-1) begin : g_top
        assign apx[N] = win[W];
      end
      if (j == 1) begin : g_first
        assign err[1] = 1'b0;
      end else begin : g_det
        logic gen_lo, prop_mid;
        assign gen_lo   = in_a[(j-2)*K +: K] > ~in_b[(j-2)*K +: K];
        assign prop_mid = &(in_a[(j-1)*K +: K] ^ in_b[(j-1)*K +: K]);
        assign err[j]   = gen_lo & prop_mid;
      end
    end
  end

  logic         s1_valid, s2_valid;
  logic [N:0]   s1_sum, s2_sum;
  logic [M-1:0] s1_err;
  logic         take, s1_bad;

  assign s1_bad   = s1_valid && (|s1_err);
  assign in_ready = !s1_bad;
  assign take     = in_valid && in_ready;

  logic [M:0] ovf;
  logic [N:0] fix;
  assign ovf[0] = 1'b0;
  for (genvar j = 0; j < M; j++) begin : g_inc
    assign {ovf[j+1], fix[j*K +: K]} =
      {1'b0, s1_sum[j*K +: K]} + {{K{1'b0}}, s1_err[j] | ovf[j]};
  end
  assign fix[N] = s1_sum[N] | ovf[M];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
      s1_sum   <= '0;
      s1_err   <= '0;
      s2_sum   <= '0;
    end else begin
      s1_valid <= take;
      if (take) begin
        s1_sum <= apx;
        s1_err <= err;
      end
      s2_valid <= s1_bad;
      if (s1_bad) s2_sum <= fix;
    end
  end

  assign out_valid = (s1_valid && !(|s1_err)) || s2_valid;
  assign out_sum   = s2_valid ? s2_sum : s1_sum;
  assign out_corr  = s2_valid;

  AST_CLEAN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !(|err)) |=> (out_valid && !out_corr && out_sum == $past({1'b0, in_a} + {1'b0, in_b}))); // R2
  AST_STALL_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (|err)) |=> !in_ready); // R3
  AST_READY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready); // R4
  AST_CORR_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_corr |-> (out_valid && $past(!in_ready))); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(take) || $past(!in_ready))); // R7
endmodule

// File: tb/approx_fix_adder_tb.sv
module approx_fix_adder_tb_top;
  localparam int N = 16;
  localparam int K = 4;
  localparam int M = N / K;
  localparam int unsigned MK = (1 << K) - 1;
  localparam int unsigned M2 = (1 << (2 * K)) - 1;
  localparam int NRAND = 2500;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [N-1:0] in_a = '0;
  logic [N-1:0] in_b = '0;
  logic         in_ready, out_valid, out_corr;
  logic [N:0]   out_sum;

  approx_fix_adder #(.N(N), .K(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_sum(out_sum),
    .out_corr(out_corr)
  );

  always #5 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [N:0] q_sum[$];
  bit         q_fix[$];
  int         q_due[$];
  string      q_tag[$];
  bit    took = 0;
  bit    held = 0;
  string cur_tag = "";
  int    prev_acc = -10;
  bit    prev_fix = 0;

  task automatic chk(bit ok, string req, string what, logic [N:0] act, logic [N:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [N:0] ref_apx(logic [N-1:0] a, logic [N-1:0] b);
    logic [N:0] r;
    int unsigned w;
    r = '0;
    for (int j = 0; j < M; j++) begin
      if (j == 0) begin
        w = (32'(a) & MK) + (32'(b) & MK);
        r[K-1:0] = w[K-1:0];
      end else begin
        w = ((32'(a) >> ((j-1)*K)) & M2) + ((32'(b) >> ((j-1)*K)) & M2);
        r[j*K +: K] = K'(w >> K);
        if (j == M-1) r[N] = w[2*K];
      end
    end
    return r;
  endfunction

  function automatic logic [N:0] ref_sum(logic [N-1:0] a, logic [N-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        bit exp_rdy;
        exp_rdy = !(prev_acc == cyc && prev_fix);
        chk(in_ready == exp_rdy, exp_rdy ? "R4" : "R3", "in_ready",
            {{N{1'b0}}, in_ready}, {{N{1'b0}}, exp_rdy});
        if (out_valid) begin
          if (q_sum.size() == 0) begin
            chk(1'b0, "R7", "out_valid with nothing due", out_sum, '0);
          end else begin
            string t;
            t = q_tag[0];
            chk(q_due[0] == cyc, t, "latency (due cycle)", N+1'(cyc), N+1'(q_due[0]));
            chk(out_sum == q_sum[0], t, "out_sum", out_sum, q_sum[0]);
            chk(out_corr == q_fix[0], t, "out_corr", {{N{1'b0}}, out_corr}, {{N{1'b0}}, q_fix[0]});
            void'(q_sum.pop_front()); void'(q_fix.pop_front());
            void'(q_due.pop_front()); void'(q_tag.pop_front());
          end
        end else if (q_sum.size() != 0 && q_due[0] <= cyc) begin
          chk(1'b0, "R7", "missing out_valid", '0, q_sum[0]);
          void'(q_sum.pop_front()); void'(q_fix.pop_front());
          void'(q_due.pop_front()); void'(q_tag.pop_front());
        end
        if (in_valid && !in_ready) held = 1;
        if (in_valid && in_ready) begin
          bit fx;
          string t;
          fx = ref_apx(in_a, in_b) != ref_sum(in_a, in_b);
          if (cur_tag != "") t = cur_tag;
          else if (held) t = "R8";
          else t = fx ? "R5" : "R2";
          q_sum.push_back(ref_sum(in_a, in_b));
          q_fix.push_back(fx);
          q_due.push_back(cyc + (fx ? 2 : 1));
          q_tag.push_back(t);
          prev_acc = cyc + 1;
          prev_fix = fx;
          held = 0;
          took = 1;
        end
      end
    end
  end

  task automatic offer(logic [N-1:0] a, logic [N-1:0] b, string tag);
    while (in_valid && !took) begin
      @(posedge clk); #1;
    end
    took = 0;
    in_valid = 1'b1;
    in_a = a;
    in_b = b;
    cur_tag = tag;
    @(posedge clk); #1;
  endtask

  initial begin
    void'($urandom(32'd7301));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", {{N{1'b0}}, out_valid}, '0);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", {{N{1'b0}}, in_ready}, {{N{1'b0}}, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", {{N{1'b0}}, out_valid}, '0);
    @(posedge clk); #1;
    offer(16'h0000, 16'h0000, "R2");
    offer(16'hFFFF, 16'h0001, "R6");
    offer(16'h00FF, 16'h0F01, "R6");
    offer(16'hFFF0, 16'h0010, "R6");
    offer(16'hFFFF, 16'hFFFF, "");
    offer(16'h8000, 16'h8000, "R2");
    offer(16'h0FFF, 16'hF001, "R6");
    offer(16'h7FFF, 16'h0001, "");
    for (int i = 0; i < NRAND; i++) begin
      logic [N-1:0] a, b;
      int unsigned mode;
      a = N'($urandom);
      mode = $urandom % 4;
      if (mode == 0) b = N'($urandom);
      else b = ~a ^ N'(1 << ($urandom % N));
      if (($urandom % 5) == 0) begin
        while (in_valid && !took) begin
          @(posedge clk); #1;
        end
        took = 0;
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
      offer(a, b, "");
    end
    while (in_valid && !took) begin
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(q_sum.size() == 0, "R7", "results left outstanding",
        N+1'(q_sum.size()), '0);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule